// File: doc/BRIEF.md
# Nested Three-State Priority Interrupt Controller

This block arbitrates among a parameterised set of interrupt levels with true nested priority. Each level is in one of three states: idle, waiting (requested but not yet taken by the processor), or active (taken but not yet finished). The block raises a single request toward the processor, together with a vector that names exactly one level, whenever an armed waiting level has no higher-priority level active. Level 0 has the highest priority.

The processor answers with a one-cycle acknowledge, which promotes the selected waiting level to active. When a service routine finishes, it sends a one-cycle return strobe, which sends the highest-priority active level back to idle. A higher-priority level can therefore interrupt a lower one at any depth, and the lower one resumes once the higher one returns. An arm register gates recognition per level. The processor writes it eight levels at a time, using a group index and a data byte.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, every level is idle, every level is disarmed, `irq_req_o` is 0 and `irq_vec_o` is 0.
- R2: A 0-to-1 transition of `irq_lines_i[i]` moves level i from idle to waiting if it is armed. A line held high does not make the level waiting again after it returns to idle. A transition on a waiting or active level has no effect.
- R3: `irq_req_o` is 1 and `irq_vec_o` equals i, one clock after the state that justifies it, exactly when i is the lowest-index armed waiting level and no active level has an index of i or less. Otherwise `irq_req_o` is 0 and `irq_vec_o` is 0.
- R4: `ack_i` moves the level selected by the R3 rule on the current state from waiting to active. When no level qualifies, the acknowledge is ignored.
- R5: `rti_i` moves the lowest-index active level back to idle. A preempted lower-priority level stays active, and a masked waiting level regains the request once nothing above it is active.
- R6: A write with `arm_we_i`=1 loads the arm bit of level `arm_sel_i*8+b` from `arm_data_i[b]` for b=0..7. Bits that map to an index of `NUM_LEVELS` or more are ignored, and a group index with no levels changes nothing.
- R7: A rising edge on a disarmed idle level is discarded. Arming that level afterwards does not raise a request.
- R8: Disarming a waiting level keeps it waiting but masks it: it raises no request and does not block lower levels. Re-arming it restores its request.
- R9: `rti_i` while no level is active changes no state.
- R10: `ack_i` and `rti_i` in the same cycle both take effect, each evaluated on the state before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | NUM_LEVELS | Request lines, bit 0 highest priority, edge-detected |
| ack_i | input | 1 | Processor acknowledge strobe |
| rti_i | input | 1 | Return-from-interrupt strobe |
| arm_we_i | input | 1 | Arm register write enable |
| arm_sel_i | input | SEL_W | Index of the eight-level group being written |
| arm_data_i | input | GROUP_W | Arm bits for the selected group |
| irq_req_o | output | 1 | Registered interrupt request to the processor |
| irq_vec_o | output | VEC_W | Registered index of the requesting level |

## Verification
A line edge changes the level state at the first clock that samples it. Because the request outputs are registered, the request reflects that edge one clock later, so the result is due two clock edges after the input is driven. An acknowledge, a return or an arm write changes state at its clock edge, and the outputs follow on the next edge. The bench drives all inputs on the falling edge. A behavioural model updates at each rising edge using the same pre-edge view, and the outputs are compared on every falling edge. The directed checks wait exactly the number of edges given above before they sample.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE = 2'b00,
    LVL_WAIT = 2'b01,
    LVL_ACT  = 2'b10
  } lvl_state_e;
endpackage

// File: rtl/prio_irq_first_set.sv
// Finds the lowest set bit of a vector (lowest index = highest priority).
module prio_irq_first_set #(
  parameter int W  = 16,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_arm_bank.sv
// Arm flip-flops, loaded one group of GROUP_W levels per write.
module prio_irq_arm_bank #(
  parameter int NUM_LEVELS = 20,
  parameter int GROUP_W    = 8,
  parameter int NUM_GROUPS = (NUM_LEVELS + GROUP_W - 1) / GROUP_W,
  parameter int SEL_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) + 1 : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [GROUP_W-1:0]    data_i,
  output logic [NUM_LEVELS-1:0] arm_o
);
  logic [NUM_LEVELS-1:0] arm_q;

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_bit
    localparam int GRP = i / GROUP_W;
    localparam int OFS = i % GROUP_W;
    always_ff @(posedge clk) begin
      if (rst) begin
        arm_q[i] <= 1'b0;
      end else if (we_i && (sel_i == SEL_W'(GRP))) begin
        arm_q[i] <= data_i[OFS];
      end
    end
  end

  assign arm_o = arm_q;

  AST_ARM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(arm_q)); // R6
endmodule

// File: rtl/prio_irq_level_cell.sv
// One priority level: edge capture and three-state tracking.
module prio_irq_level_cell
  import prio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic armed_i,
  input  logic grant_i,
  input  logic retire_i,
  output logic pend_o,
  output logic active_o
);
  logic       line_q;
  logic       rise;
  lvl_state_e st_q;

  assign rise = line_i & ~line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      st_q   <= LVL_IDLE;
    end else begin
      line_q <= line_i;
      if (retire_i) begin
        st_q <= LVL_IDLE;
      end else if (grant_i) begin
        st_q <= LVL_ACT;
      end else if ((st_q == LVL_IDLE) && rise && armed_i) begin
        st_q <= LVL_WAIT;
      end
    end
  end

  assign pend_o   = (st_q == LVL_WAIT) && armed_i;
  assign active_o = (st_q == LVL_ACT);

  AST_GRANT_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
    grant_i |-> (st_q == LVL_WAIT)); // R4
  AST_GRANT_TO_ACT: assert property (@(posedge clk) disable iff (rst)
    (grant_i && !retire_i) |=> (st_q == LVL_ACT)); // R4
  AST_RETIRE_FROM_ACT: assert property (@(posedge clk) disable iff (rst)
    retire_i |-> (st_q == LVL_ACT)); // R5
  AST_RETIRE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    retire_i |=> (st_q == LVL_IDLE)); // R5
  AST_DISARMED_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    ((st_q == LVL_IDLE) && !armed_i) |=> (st_q != LVL_WAIT)); // R7
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_LEVELS = 20,
  parameter int GROUP_W    = 8,
  localparam int NUM_GROUPS = (NUM_LEVELS + GROUP_W - 1) / GROUP_W,
  localparam int SEL_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) + 1 : 1,
  localparam int VEC_W      = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] irq_lines_i,
  input  logic                  ack_i,
  input  logic                  rti_i,
  input  logic                  arm_we_i,
  input  logic [SEL_W-1:0]      arm_sel_i,
  input  logic [GROUP_W-1:0]    arm_data_i,
  output logic                  irq_req_o,
  output logic [VEC_W-1:0]      irq_vec_o
);
  logic [NUM_LEVELS-1:0] arm;
  logic [NUM_LEVELS-1:0] pend_vec;
  logic [NUM_LEVELS-1:0] act_vec;
  logic [NUM_LEVELS-1:0] grant_vec;
  logic [NUM_LEVELS-1:0] retire_vec;
  logic                  w_found, a_found;
  logic [VEC_W-1:0]      w_idx, a_idx;
  logic                  qualify;
  logic [NUM_LEVELS-1:0] one_hot_base;

  assign one_hot_base = NUM_LEVELS'(1);

  prio_irq_arm_bank #(
    .NUM_LEVELS (NUM_LEVELS),
    .GROUP_W    (GROUP_W),
    .NUM_GROUPS (NUM_GROUPS),
    .SEL_W      (SEL_W)
  ) u_arm (
    .clk    (clk),
    .rst    (rst),
    .we_i   (arm_we_i),
    .sel_i  (arm_sel_i),
    .data_i (arm_data_i),
    .arm_o  (arm)
  );

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
    prio_irq_level_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .line_i   (irq_lines_i[i]),
      .armed_i  (arm[i]),
      .grant_i  (grant_vec[i]),
      .retire_i (retire_vec[i]),
      .pend_o   (pend_vec[i]),
      .active_o (act_vec[i])
    );
  end

  prio_irq_first_set #(.W(NUM_LEVELS), .IW(VEC_W)) u_pend_enc (
    .vec_i   (pend_vec),
    .found_o (w_found),
    .idx_o   (w_idx)
  );

  prio_irq_first_set #(.W(NUM_LEVELS), .IW(VEC_W)) u_act_enc (
    .vec_i   (act_vec),
    .found_o (a_found),
    .idx_o   (a_idx)
  );

  assign qualify    = w_found && (!a_found || (w_idx < a_idx));
  assign grant_vec  = (ack_i && qualify) ? (one_hot_base << w_idx) : '0;
  assign retire_vec = (rti_i && a_found) ? (one_hot_base << a_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req_o <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_req_o <= qualify;
      irq_vec_o <= qualify ? w_idx : '0;
    end
  end

  AST_NEW_ACT_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    (|grant_vec) |=> ((act_vec & ($past(grant_vec) - 1'b1)) == '0)); // R4
  AST_RTI_EMPTY_NOP: assert property (@(posedge clk) disable iff (rst)
    (rti_i && !(|act_vec) && !ack_i) |=> (act_vec == '0)); // R9
  AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !irq_req_o |-> (irq_vec_o == '0)); // R3
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 20;
  localparam int GW   = 8;
  localparam int NG   = (NL + GW - 1) / GW;
  localparam int SW   = (NG > 1) ? $clog2(NG) + 1 : 1;
  localparam int VW   = $clog2(NL);
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] lines = '0;
  logic          ack = 1'b0, rti = 1'b0, we = 1'b0;
  logic [SW-1:0] sel = '0;
  logic [GW-1:0] data = '0;
  logic          irq_req;
  logic [VW-1:0] irq_vec;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state: 0 idle, 1 waiting, 2 active
  int m_st[NL];
  bit m_arm[NL];
  bit m_prev[NL];
  bit exp_req;
  int exp_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_LEVELS(NL), .GROUP_W(GW)) u_dut (
    .clk (clk), .rst (rst), .irq_lines_i (lines), .ack_i (ack), .rti_i (rti),
    .arm_we_i (we), .arm_sel_i (sel), .arm_data_i (data),
    .irq_req_o (irq_req), .irq_vec_o (irq_vec)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_arm[i] = 0; m_prev[i] = 0; end
      exp_req = 0; exp_vec = 0;
    end else begin
      int hw, ha, g, r;
      int old_st[NL];
      bit old_arm[NL];
      hw = -1; ha = -1; g = -1; r = -1;
      for (int i = 0; i < NL; i++) begin old_st[i] = m_st[i]; old_arm[i] = m_arm[i]; end
      for (int i = NL - 1; i >= 0; i--) begin
        if (old_st[i] == 1 && old_arm[i]) hw = i;
        if (old_st[i] == 2) ha = i;
      end
      if (hw >= 0 && (ha < 0 || hw < ha)) begin exp_req = 1; exp_vec = hw; end
      else begin exp_req = 0; exp_vec = 0; end
      if (ack && exp_req) g = hw;
      if (rti && ha >= 0) r = ha;
      for (int i = 0; i < NL; i++) begin
        if (i == r) m_st[i] = 0;
        else if (i == g) m_st[i] = 2;
        else if (old_st[i] == 0 && old_arm[i] && lines[i] && !m_prev[i]) m_st[i] = 1;
        m_prev[i] = lines[i];
      end
      if (we && int'(sel) < NG) begin
        for (int b = 0; b < GW; b++) begin
          if (int'(sel) * GW + b < NL) m_arm[int'(sel) * GW + b] = data[b];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      tests++;
      if (irq_req !== exp_req || int'(irq_vec) != exp_vec) begin
        fails++;
        $display("FAIL %s cycle-model: actual req=%0b vec=%0d expected req=%0b vec=%0d",
                 cur_req, irq_req, irq_vec, exp_req, exp_vec);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input bit er, input int ev, input string tag);
    tests++;
    if (irq_req !== er || int'(irq_vec) != ev) begin
      fails++;
      $display("FAIL %s directed: actual req=%0b vec=%0d expected req=%0b vec=%0d",
               tag, irq_req, irq_vec, er, ev);
    end
  endtask

  task automatic pulse_line(input int i);
    lines[i] = 1'b1; step(1); lines[i] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic do_rti();
    rti = 1'b1; step(1); rti = 1'b0;
  endtask

  task automatic arm_write(input int s, input logic [GW-1:0] d);
    we = 1'b1; sel = SW'(s); data = d; step(1); we = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    cur_req = "R1";
    expect_out(0, 0, "R1");
    // R7: edge on a disarmed level is lost
    cur_req = "R7";
    pulse_line(3); step(1);
    expect_out(0, 0, "R7");
    // R6: group loads, out-of-range group ignored
    cur_req = "R6";
    arm_write(0, 8'hFF); arm_write(1, 8'hFF); arm_write(2, 8'h0F); arm_write(3, 8'hFF);
    step(1);
    expect_out(0, 0, "R7");
    cur_req = "R2";
    pulse_line(5); step(1);
    expect_out(1, 5, "R2");
    cur_req = "R3";
    pulse_line(2); step(1);
    expect_out(1, 2, "R3");
    cur_req = "R4";
    do_ack(); step(1);
    expect_out(0, 0, "R4");
    do_ack(); step(1);
    expect_out(0, 0, "R4");
    cur_req = "R5";
    pulse_line(1); step(1);
    expect_out(1, 1, "R5");
    do_ack(); step(1);
    expect_out(0, 0, "R4");
    do_rti(); step(1);
    expect_out(0, 0, "R5");
    do_rti(); step(1);
    expect_out(1, 5, "R5");
    do_ack(); do_rti(); step(1);
    expect_out(0, 0, "R5");
    cur_req = "R9";
    do_rti(); step(1);
    expect_out(0, 0, "R9");
    cur_req = "R2";
    lines[7] = 1'b1; step(2);
    expect_out(1, 7, "R2");
    do_ack(); do_rti(); step(2);
    expect_out(0, 0, "R2");
    lines[7] = 1'b0; step(1);
    cur_req = "R8";
    pulse_line(4); pulse_line(9); step(1);
    expect_out(1, 4, "R3");
    arm_write(0, 8'hEF); step(1);
    expect_out(1, 9, "R8");
    arm_write(0, 8'hFF); step(1);
    expect_out(1, 4, "R8");
    cur_req = "R10";
    do_ack(); step(1);
    expect_out(0, 0, "R10");
    pulse_line(2); step(1);
    expect_out(1, 2, "R10");
    ack = 1'b1; rti = 1'b1; step(1); ack = 1'b0; rti = 1'b0; step(1);
    expect_out(0, 0, "R10");
    do_rti(); step(1);
    expect_out(1, 9, "R10");
    do_ack(); do_rti(); step(1);
    cur_req = "R6";
    arm_write(2, 8'hF0);
    pulse_line(19); step(1);
    expect_out(0, 0, "R6");
    arm_write(2, 8'h0F);
    pulse_line(18); step(1);
    expect_out(1, 18, "R6");
    do_ack(); do_rti(); step(1);
    arm_write(3, 8'h00);
    pulse_line(0); step(1);
    expect_out(1, 0, "R6");
    do_ack(); do_rti(); step(1);
    // mixed traffic against the model
    cur_req = "R3";
    for (int k = 0; k < 4000; k++) begin
      lines = NL'($urandom & $urandom & $urandom);
      ack   = ($urandom_range(0, 3) == 0);
      rti   = ($urandom_range(0, 4) == 0);
      we    = ($urandom_range(0, 15) == 0);
      sel   = SW'($urandom_range(0, 3));
      data  = GW'($urandom | $urandom);
      step(1);
    end
    lines = '0; ack = 0; rti = 0; we = 0;
    step(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule